// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Request Logic

This block holds the status flags of an SPI peripheral whose receive and transmit paths each have an 8-byte FIFO. It has two modes. In single-buffer mode the receive path behaves as one holding register. In FIFO mode the flags follow the occupancy of the two FIFOs and add watermark flags, so that software or DMA can refill or drain a FIFO before it runs dry or overflows. The shift engine, the clock generator and the FIFO storage are outside the block. The shift engine reaches it as a transfer-complete pulse, and the FIFOs reach it as occupancy counts.

Every flag is registered, so an event or a count change appears in the status byte on the clock edge after it. Changing any configuration bit (mode select, FIFO mode or enable) raises a one-cycle flush request toward the FIFOs. The same change reloads the flags with values that depend on the mode. The interrupt line and the receive DMA request are formed from the registered flags and the enable inputs, with no further delay.

Top module: `spi_status_flags`

## Requirements
- R1: `status` bit positions are: 7 receive-full, 6 match, 5 transmit-empty, 4 mode-fault, 3 receive-nearly-full, 2 transmit-nearly-empty, 1 transmit-full, 0 receive-FIFO-empty.
- R2: While reset is asserted, `status`, `irq` and `rx_dma_req` are all 0.
- R3: In a cycle where `cfg_mode_sel`, `cfg_fifo_en` or `cfg_enable` differs from its value in the previous cycle, `cfg_flush` is 1. At the next edge, receive-full, match, mode-fault, receive-nearly-full and transmit-full clear to 0. Transmit-empty loads 1. Transmit-nearly-empty and receive-FIFO-empty load the new value of `cfg_fifo_en`.
- R4: In single-buffer mode (`cfg_fifo_en`=0), a `xfer_done` pulse sets receive-full at the next edge.
- R5: In single-buffer mode with `rxdma_en`=0, receive-full clears only in this sequence: a `stat_rd` while the flag is set, then a later `data_rd`. A `data_rd` that is not preceded by such a `stat_rd` leaves the flag set.
- R6: With `rxdma_en`=1, a `dma_done` pulse clears receive-full. `rx_dma_req` is 1 exactly when `rxdma_en` is 1 and receive-full is set.
- R7: In FIFO mode, receive-full is set when `rx_count` is 8 and `data_rd` is 0 in that cycle. With `rxdma_en`=0, a `data_rd` clears it.
- R8: In FIFO mode, receive-nearly-full follows `rx_count` >= 6 and transmit-nearly-empty follows `tx_count` <= 2, each registered one cycle later.
- R9: In FIFO mode, transmit-full follows `tx_count` == 8 and receive-FIFO-empty follows `rx_count` == 0. In single-buffer mode these two flags and both watermark flags are 0. Transmit-empty follows `tx_count` == 0 in both modes.
- R10: If `xfer_done` arrives in the same cycle as a read or DMA-done that would clear receive-full, the flag stays set.
- R11: `irq` is 1 when `rx_ie` is 1 and receive-full or mode-fault is set, or when `rnf_ie` is 1 and receive-nearly-full is set, or when `tne_ie` is 1 and transmit-nearly-empty is set. Otherwise it is 0.
- R12: Pulses on `match_evt` and `modf_evt` set the match and mode-fault flags. A flag stays set until a `stat_rd` arrives while it is set, and then it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode_sel | input | 1 | Mode-select configuration bit |
| cfg_fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-buffer mode |
| cfg_enable | input | 1 | Peripheral enable bit |
| rx_ie | input | 1 | Interrupt enable for receive-full and mode-fault |
| rnf_ie | input | 1 | Interrupt enable for receive-nearly-full |
| tne_ie | input | 1 | Interrupt enable for transmit-nearly-empty |
| rxdma_en | input | 1 | Receive DMA enable |
| xfer_done | input | 1 | One-cycle pulse from the shifter when a transfer completes |
| match_evt | input | 1 | One-cycle pulse on a receive data match |
| modf_evt | input | 1 | One-cycle pulse on a mode fault |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| dma_done | input | 1 | Receive DMA transfer done pulse |
| rx_count | input | 4 | Receive FIFO occupancy, 0 to 8 |
| tx_count | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| cfg_flush | output | 1 | Flush request to both FIFOs on a configuration change |

## Verification
In FIFO mode, a table of occupancy pairs walks both counts across every threshold: 0, 1, 2, 3, 5, 6, 7 and 8. This separates an off-by-one watermark or full compare from a correct one, and it shows that receive-full stays set after the count falls. Directed sequences cover the other cases:
- In single-buffer mode, a data read with no status read first, set against the full two-step sequence.
- A full receive FIFO combined with a coinciding data read, and with a data read plus a transfer.
- Configuration changes made while the counts would imply other flag values. This shows that the reload values come from the mode and not from the counts.
- The interrupt enables switched one at a time, and the DMA clear path.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  // Member order fixes the status byte layout: first member is bit 7.
  typedef struct packed {
    logic rx_full;
    logic match;
    logic tx_empty;
    logic mode_fault;
    logic rx_near_full;
    logic tx_near_empty;
    logic tx_full;
    logic rx_fifo_empty;
  } stat_t;

  typedef struct packed {
    logic mode_sel;
    logic fifo_en;
    logic enable;
  } cfg_t;

  localparam int STAT_W = $bits(stat_t);
  localparam int CFG_W  = $bits(cfg_t);

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_watch.sv
module spi_cfg_watch
  import spi_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_i,
  output logic flush_o
);
  cfg_t prev_q;
  cfg_t prev_d;
  logic prev_en;

  always_comb begin
    prev_en = 1'b1;
    prev_d  = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  assign flush_o = rst_n && (cfg_i != prev_q);
endmodule

// File: rtl/spi_rxfull_ctl.sv
module spi_rxfull_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic flush,
  input  logic fifo_at_full,
  input  logic xfer_done,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic dma_done,
  input  logic rxdma_en,
  output logic rx_full
);
  logic full_q, full_d;
  logic armed_q, armed_d;
  logic set_evt, rd_clr, dma_clr, clr_evt;

  always_comb begin
    set_evt = fifo_mode ? (fifo_at_full && !data_rd) : xfer_done;
    rd_clr  = !rxdma_en && data_rd && (fifo_mode || armed_q);
    dma_clr = rxdma_en && dma_done;
    clr_evt = (rd_clr || dma_clr) && !xfer_done;

    if (flush)        full_d = 1'b0;
    else if (set_evt) full_d = 1'b1;
    else if (clr_evt) full_d = 1'b0;
    else              full_d = full_q;

    if (flush || data_rd)          armed_d = 1'b0;
    else if (stat_rd && full_q)    armed_d = 1'b1;
    else                           armed_d = armed_q && full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      armed_q <= armed_d;
    end
  end

  assign rx_full = full_q;
endmodule

// File: rtl/spi_level_flags.sv
module spi_level_flags #(
  parameter int DEPTH = 8,
  parameter int RX_WM = 6,
  parameter int TX_WM = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          flush,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_near_full,
  output logic          tx_near_empty,
  output logic          tx_full,
  output logic          rx_fifo_empty,
  output logic          tx_empty
);
  localparam logic [CW-1:0] RX_MARK = CW'(RX_WM);
  localparam logic [CW-1:0] TX_MARK = CW'(TX_WM);
  localparam logic [CW-1:0] FULLV   = CW'(DEPTH);

  logic [4:0] lvl_q, lvl_d;
  logic       lvl_en;

  always_comb begin
    lvl_en = 1'b1;
    if (flush) begin
      lvl_d = {1'b0, fifo_mode, 1'b0, fifo_mode, 1'b1};
    end else begin
      lvl_d[4] = fifo_mode && (rx_count >= RX_MARK);
      lvl_d[3] = fifo_mode && (tx_count <= TX_MARK);
      lvl_d[2] = fifo_mode && (tx_count == FULLV);
      lvl_d[1] = fifo_mode && (rx_count == '0);
      lvl_d[0] = (tx_count == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign rx_near_full  = lvl_q[4];
  assign tx_near_empty = lvl_q[3];
  assign tx_full       = lvl_q[2];
  assign rx_fifo_empty = lvl_q[1];
  assign tx_empty      = lvl_q[0];
endmodule

// File: rtl/spi_sticky_flags.sv
module spi_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         stat_rd,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d;
    always_comb begin
      if (flush)                d = 1'b0;
      else if (evt[i])          d = 1'b1;
      else if (stat_rd && q)    d = 1'b0;
      else                      d = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flag[i] = q;
  end
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RX_WM = 6,
  parameter int TX_WM = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode_sel,
  input  logic          cfg_fifo_en,
  input  logic          cfg_enable,
  input  logic          rx_ie,
  input  logic          rnf_ie,
  input  logic          tne_ie,
  input  logic          rxdma_en,
  input  logic          xfer_done,
  input  logic          match_evt,
  input  logic          modf_evt,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          dma_done,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic [7:0]    status,
  output logic          irq,
  output logic          rx_dma_req,
  output logic          cfg_flush
);
  logic  rst_q_n;
  cfg_t  cfg;
  stat_t st;
  logic  flush;
  logic  fifo_at_full;
  logic [1:0] sticky;

  assign cfg = '{mode_sel: cfg_mode_sel, fifo_en: cfg_fifo_en, enable: cfg_enable};
  assign fifo_at_full = (rx_count == CW'(DEPTH));

  spi_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  spi_cfg_watch u_cfg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .cfg_i   (cfg),
    .flush_o (flush)
  );

  spi_rxfull_ctl u_rxf (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .fifo_mode    (cfg_fifo_en),
    .flush        (flush),
    .fifo_at_full (fifo_at_full),
    .xfer_done    (xfer_done),
    .stat_rd      (stat_rd),
    .data_rd      (data_rd),
    .dma_done     (dma_done),
    .rxdma_en     (rxdma_en),
    .rx_full      (st.rx_full)
  );

  spi_level_flags #(.DEPTH(DEPTH), .RX_WM(RX_WM), .TX_WM(TX_WM)) u_lvl (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .fifo_mode     (cfg_fifo_en),
    .flush         (flush),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .rx_near_full  (st.rx_near_full),
    .tx_near_empty (st.tx_near_empty),
    .tx_full       (st.tx_full),
    .rx_fifo_empty (st.rx_fifo_empty),
    .tx_empty      (st.tx_empty)
  );

  spi_sticky_flags #(.N(2)) u_stk (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .flush   (flush),
    .stat_rd (stat_rd),
    .evt     ({match_evt, modf_evt}),
    .flag    (sticky)
  );

  assign st.match      = sticky[1];
  assign st.mode_fault = sticky[0];

  assign status     = st;
  assign cfg_flush  = flush;
  assign rx_dma_req = rxdma_en && st.rx_full;
  assign irq        = (rx_ie  && (st.rx_full || st.mode_fault))
                   || (rnf_ie && st.rx_near_full)
                   || (tne_ie && st.tx_near_empty);
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk #(
  parameter int DEPTH = 8,
  parameter int RX_WM = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fifo_en,
  input logic          xfer_done,
  input logic          dma_done,
  input logic          data_rd,
  input logic          rxdma_en,
  input logic          rx_ie,
  input logic          rnf_ie,
  input logic          tne_ie,
  input logic [CW-1:0] rx_count,
  input logic [7:0]    status,
  input logic          irq,
  input logic          cfg_flush
);
  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (status == 8'h00); // R2
  end

  AST_CFG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flush |=> (status[2] == $past(cfg_fifo_en) && status[0] == $past(cfg_fifo_en)
                   && status[7] == 1'b0 && status[5] == 1'b1)); // R3

  AST_SB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && xfer_done && !cfg_flush) |=> status[7]); // R4

  AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rxdma_en && dma_done && !xfer_done && !cfg_flush
     && (!cfg_fifo_en || rx_count != CW'(DEPTH))) |=> !status[7]); // R6

  AST_XFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && xfer_done && !cfg_flush) |=> status[7]); // R10

  AST_RNF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_en && !cfg_flush) |=> (status[3] == ($past(rx_count) >= CW'(RX_WM)))); // R8

  AST_SB_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && !cfg_flush) |=> (status[1] == 1'b0 && status[0] == 1'b0)); // R9

  AST_FIFO_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_en && !rxdma_en && data_rd && !xfer_done) |=> !status[7]); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !rnf_ie && !tne_ie) |-> !irq); // R11
endmodule

bind spi_status_flags spi_stat_chk #(.DEPTH(DEPTH), .RX_WM(RX_WM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cfg_fifo_en (cfg_fifo_en),
  .xfer_done   (xfer_done),
  .dma_done    (dma_done),
  .data_rd     (data_rd),
  .rxdma_en    (rxdma_en),
  .rx_ie       (rx_ie),
  .rnf_ie      (rnf_ie),
  .tne_ie      (tne_ie),
  .rx_count    (rx_count),
  .status      (status),
  .irq         (irq),
  .cfg_flush   (cfg_flush)
);

// File: tb/sim_spi_status_flags.sv
`timescale 1ns/1ps
module sim_spi_status_flags;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mode_sel, cfg_fifo_en, cfg_enable;
  logic rx_ie, rnf_ie, tne_ie, rxdma_en;
  logic xfer_done, match_evt, modf_evt, stat_rd, data_rd, dma_done;
  logic [3:0] rx_count, tx_count;
  logic [7:0] status;
  logic irq, rx_dma_req, cfg_flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_status_flags u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode_sel(cfg_mode_sel), .cfg_fifo_en(cfg_fifo_en),
    .cfg_enable(cfg_enable), .rx_ie(rx_ie), .rnf_ie(rnf_ie), .tne_ie(tne_ie),
    .rxdma_en(rxdma_en), .xfer_done(xfer_done), .match_evt(match_evt),
    .modf_evt(modf_evt), .stat_rd(stat_rd), .data_rd(data_rd), .dma_done(dma_done),
    .rx_count(rx_count), .tx_count(tx_count), .status(status), .irq(irq),
    .rx_dma_req(rx_dma_req), .cfg_flush(cfg_flush)
  );

  // {rx_count, tx_count, expected status}; FIFO mode, no events
  localparam logic [15:0] VECS [8] = '{
    16'h0025, 16'h5300, 16'h620C, 16'h780A,
    16'h1104, 16'h8488, 16'h8488, 16'h30A4
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic pulses_off();
    xfer_done = 0; match_evt = 0; modf_evt = 0;
    stat_rd = 0; data_rd = 0; dma_done = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_mode_sel = 0; cfg_fifo_en = 0; cfg_enable = 0;
    rx_ie = 0; rnf_ie = 0; tne_ie = 0; rxdma_en = 0;
    pulses_off();
    rx_count = 0; tx_count = 0;
    cyc(); cyc();
    // R2: reset state
    chk8("R2 status in reset", status, 8'h00);
    chk1("R2 irq in reset", irq, 1'b0);
    chk1("R2 dma req in reset", rx_dma_req, 1'b0);
    rst_n = 1;
    repeat (4) cyc();
    // R9: single-buffer, tx empty only
    chk8("R9 single-buffer idle", status, 8'h20);

    // R3: switch to FIFO mode with counts that would not give these flags
    cfg_fifo_en = 1; cfg_enable = 1; rx_count = 5; tx_count = 5;
    #1;
    chk1("R3 flush on cfg change", cfg_flush, 1'b1);
    cyc();
    chk8("R3 FIFO-mode reload", status, 8'h25);
    chk1("R3 flush one cycle", cfg_flush, 1'b0);
    cyc();
    chk8("R8 counts 5/5", status, 8'h00);

    // R7 R8 R9 R1: table walk
    for (int i = 0; i < 8; i++) begin
      rx_count = VECS[i][15:12];
      tx_count = VECS[i][11:8];
      cyc();
      chk8($sformatf("R8 R9 R7 R1 vector %0d", i), status, VECS[i][7:0]);
    end

    // R7: data read clears receive-full in FIFO mode
    rx_count = 7; tx_count = 5; data_rd = 1;
    cyc();
    chk8("R7 data read clears", status, 8'h08);
    rx_count = 8;
    cyc();
    chk8("R7 no set while data read", status, 8'h08);
    data_rd = 0;
    cyc();
    chk8("R7 set at full", status, 8'h88);
    // R10: transfer coincides with clearing read
    data_rd = 1; xfer_done = 1;
    cyc();
    chk8("R10 FIFO coincident read", status, 8'h88);
    pulses_off(); data_rd = 1; rx_count = 7;
    cyc();
    chk8("R7 clear after coincidence", status, 8'h08);
    pulses_off();

    // R11: watermark interrupt enables
    rx_count = 6; tx_count = 5;
    cyc();
    chk1("R11 rnf masked", irq, 1'b0);
    rnf_ie = 1; #1;
    chk1("R11 rnf enabled", irq, 1'b1);
    rnf_ie = 0; rx_count = 3; tx_count = 2;
    cyc();
    chk1("R11 tne masked", irq, 1'b0);
    tne_ie = 1; #1;
    chk1("R11 tne enabled", irq, 1'b1);
    tne_ie = 0;

    // R3 R9: back to single-buffer mode, counts ignored
    cfg_fifo_en = 0; rx_count = 6; tx_count = 1;
    cyc();
    chk8("R3 single-buffer reload", status, 8'h20);
    cyc();
    chk8("R9 single-buffer forced zero", status, 8'h00);
    rx_count = 0; tx_count = 0;
    cyc();
    chk8("R9 tx empty", status, 8'h20);

    // R4 R11
    rx_ie = 1; xfer_done = 1;
    cyc(); pulses_off();
    chk8("R4 set on transfer", status, 8'hA0);
    chk1("R11 rx irq", irq, 1'b1);
    chk1("R6 no dma req when disabled", rx_dma_req, 1'b0);
    // R5: data read alone does not clear
    data_rd = 1;
    cyc(); pulses_off();
    chk8("R5 data read without status read", status, 8'hA0);
    stat_rd = 1;
    cyc(); pulses_off();
    chk8("R5 status read alone", status, 8'hA0);
    data_rd = 1;
    cyc(); pulses_off();
    chk8("R5 two-step clear", status, 8'h20);
    // R10 in single-buffer mode
    xfer_done = 1; cyc(); pulses_off();
    stat_rd = 1; cyc(); pulses_off();
    data_rd = 1; xfer_done = 1; cyc(); pulses_off();
    chk8("R10 single coincident read", status, 8'hA0);
    data_rd = 1; cyc(); pulses_off();
    chk8("R5 arming consumed", status, 8'hA0);
    stat_rd = 1; cyc(); pulses_off();
    data_rd = 1; cyc(); pulses_off();
    chk8("R5 second two-step clear", status, 8'h20);

    // R6: DMA path
    rxdma_en = 1; xfer_done = 1;
    cyc(); pulses_off();
    chk1("R6 dma req", rx_dma_req, 1'b1);
    stat_rd = 1; cyc(); pulses_off();
    data_rd = 1; cyc(); pulses_off();
    chk8("R6 read ignored with dma", status, 8'hA0);
    dma_done = 1;
    cyc(); pulses_off();
    chk8("R6 dma done clears", status, 8'h20);
    chk1("R6 dma req drops", rx_dma_req, 1'b0);
    rxdma_en = 0;

    // R12 R11: sticky flags
    modf_evt = 1;
    cyc(); pulses_off();
    chk8("R12 mode fault set", status, 8'h30);
    chk1("R11 modf irq", irq, 1'b1);
    rx_ie = 0; #1;
    chk1("R11 modf masked", irq, 1'b0);
    cyc();
    chk8("R12 mode fault held", status, 8'h30);
    stat_rd = 1;
    cyc(); pulses_off();
    chk8("R12 status read clears", status, 8'h20);
    match_evt = 1;
    cyc(); pulses_off();
    chk8("R12 match set", status, 8'h60);
    stat_rd = 1;
    cyc(); pulses_off();
    chk8("R12 match cleared", status, 8'h20);

    // R2: reset mid-run in FIFO mode
    cfg_fifo_en = 1; xfer_done = 1;
    cyc(); pulses_off();
    rst_n = 0; #1;
    chk8("R2 asynchronous clear", status, 8'h00);
    rst_n = 1;
    repeat (3) cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule